// File: doc/BRIEF.md
# Rail Limit Sticky Interrupt Status

This block watches two sampled supply readings, one from the standby rail and one from the battery rail. Whenever the sample strobe is high, it checks each reading against its own pair of programmable limits. A reading is a violation when it is at or below the low limit, or strictly above the high limit. A violation on an enabled channel sets that channel's bit in a two-bit sticky status register. The bit stays set until software clears it.

Software reads the status through a one-register port. To clear a bit, software writes a 1 to it. The clear takes effect only if the condition that set the bit has gone away. Clearing a channel's own enable also clears its status bit.

A group enable and a global enable sit in front of the interrupt output. They gate only that output and never change the stored status.

Top module: `vrail_irq_status`

## Requirements
- R1: After reset the status reads 00h and the interrupt output is 0. Bits 7 to 2 of the read data always read 0.
- R2: When a strobe cycle has the standby reading at or below its low limit, or strictly above its high limit, and the standby enable is 1, status bit 0 is 1 from the next cycle. A reading equal to the high limit does not set the bit.
- R3: The battery reading follows the same rule as R2, using its own limits, its own enable and status bit 1.
- R4: A set bit stays 1 after later strobes show the reading back inside its limits, as long as no clear occurs.
- R5: Writing 1 to a status bit clears it on the next cycle only when its channel is not currently in violation. The current violation state is the one from the latest strobe, or from the same cycle if the strobe is high during the write. While the violation persists, the write leaves the bit at 1.
- R6: Writing 0 to a status bit leaves it unchanged.
- R7: When a strobe sets a bit in the same cycle that a write of 1 targets it, the bit is 1 on the next cycle.
- R8: While a channel's enable is 0, its status bit reads 0 from the next cycle, and violations on that channel do not set it. Setting the enable back to 1 does not restore the bit.
- R9: The interrupt output is 1 exactly when any status bit is 1 and both the group enable and the global enable are 1. Changing either gate leaves the status unchanged.
- R10: Readings presented while the strobe is 0 are not evaluated and set no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Strobe that marks both readings as valid |
| stby_rd | input | 8 | Standby rail reading, unsigned |
| batt_rd | input | 8 | Battery rail reading, unsigned |
| stby_lo | input | 8 | Standby low limit |
| stby_hi | input | 8 | Standby high limit |
| batt_lo | input | 8 | Battery low limit |
| batt_hi | input | 8 | Battery high limit |
| ch_en | input | 2 | Per-channel enables: bit 0 standby, bit 1 battery |
| grp_en | input | 1 | Voltage group interrupt gate |
| glb_en | input | 1 | Global interrupt gate |
| reg_wr | input | 1 | Write strobe for the status register |
| reg_wdata | input | 8 | Write data; a 1 requests a clear of that bit |
| reg_rdata | output | 8 | Status read data; bits 7 to 2 are 0 |
| irq | output | 1 | Gated interrupt output |

## Verification
Each status change caused by a strobe, a write or an enable change is registered once. It therefore becomes visible on the read data one clock edge after the cycle that carries the stimulus. The interrupt output, in contrast, follows the gate inputs within the same cycle. The bench drives every stimulus for one cycle just after a falling edge. It samples shortly after the next rising edge, so that each check lands in the first cycle where the new value is due. Gate checks are sampled before any further edge.

// File: rtl/vrail_pkg.sv
package vrail_pkg;
    localparam int NCH = 2;   // channel 0 standby, channel 1 battery
    localparam int RW  = 8;   // register width

    typedef struct packed {
        logic [NCH-1:0] sts;   // sticky status
        logic [NCH-1:0] viol;  // violation seen at the latest strobe
    } vsts_state_t;
endpackage

// File: rtl/vlim_cmp.sv
module vlim_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] rd,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic         viol
);
    logic below_d;
    logic above_d;

    always_comb begin
        below_d = (rd <= lo);
        above_d = (rd > hi);
        viol    = below_d | above_d;
    end
endmodule

// File: rtl/vsts_core.sv
module vsts_core
    import vrail_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           smp_valid,
    input  logic [NCH-1:0] viol_now,
    input  logic [NCH-1:0] ch_en,
    input  logic           wr,
    input  logic [NCH-1:0] wclr,
    output logic [NCH-1:0] sts
);
    vsts_state_t st_d, st_q;
    logic [NCH-1:0] active_d;
    logic [NCH-1:0] set_d;
    logic [NCH-1:0] clr_d;

    always_comb begin
        st_d     = st_q;
        active_d = smp_valid ? viol_now : st_q.viol;
        set_d    = '0;
        clr_d    = '0;
        if (smp_valid) begin
            st_d.viol = viol_now;
        end
        for (int i = 0; i < NCH; i++) begin
            set_d[i] = smp_valid & viol_now[i] & ch_en[i];
            clr_d[i] = wr & wclr[i] & ~active_d[i];
            if (!ch_en[i]) begin
                st_d.sts[i] = 1'b0;
            end else if (set_d[i]) begin
                st_d.sts[i] = 1'b1;
            end else if (clr_d[i]) begin
                st_d.sts[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sts = st_q.sts;
endmodule

// File: rtl/vsts_readout.sv
module vsts_readout
    import vrail_pkg::*;
(
    input  logic [NCH-1:0] sts,
    input  logic           grp_en,
    input  logic           glb_en,
    output logic [RW-1:0]  rdata,
    output logic           irq
);
    localparam int PADW = RW - NCH;

    always_comb begin
        rdata = {{PADW{1'b0}}, sts};
        irq   = (|sts) & grp_en & glb_en;
    end
endmodule

// File: rtl/vrail_irq_status.sv
module vrail_irq_status
    import vrail_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           smp_valid,
    input  logic [7:0]     stby_rd,
    input  logic [7:0]     batt_rd,
    input  logic [7:0]     stby_lo,
    input  logic [7:0]     stby_hi,
    input  logic [7:0]     batt_lo,
    input  logic [7:0]     batt_hi,
    input  logic [1:0]     ch_en,
    input  logic           grp_en,
    input  logic           glb_en,
    input  logic           reg_wr,
    input  logic [7:0]     reg_wdata,
    output logic [7:0]     reg_rdata,
    output logic           irq
);
    localparam int DW = 8;

    logic [NCH-1:0][DW-1:0] rd_a;
    logic [NCH-1:0][DW-1:0] lo_a;
    logic [NCH-1:0][DW-1:0] hi_a;
    logic [NCH-1:0]         viol_now;
    logic [NCH-1:0]         sts;
    logic                   wdata_unused;

    assign rd_a         = {batt_rd, stby_rd};
    assign lo_a         = {batt_lo, stby_lo};
    assign hi_a         = {batt_hi, stby_hi};
    assign wdata_unused = ^reg_wdata[RW-1:NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_cmp
        vlim_cmp #(.W(DW)) cmp_i (
            .rd   (rd_a[g]),
            .lo   (lo_a[g]),
            .hi   (hi_a[g]),
            .viol (viol_now[g])
        );
    end

    vsts_core core_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .viol_now  (viol_now),
        .ch_en     (ch_en),
        .wr        (reg_wr),
        .wclr      (reg_wdata[NCH-1:0]),
        .sts       (sts)
    );

    vsts_readout out_i (
        .sts    (sts),
        .grp_en (grp_en),
        .glb_en (glb_en),
        .rdata  (reg_rdata),
        .irq    (irq)
    );
endmodule

// File: rtl/vrail_irq_status_chk.sv
module vrail_irq_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       smp_valid,
    input logic [7:0] stby_rd,
    input logic [7:0] batt_rd,
    input logic [7:0] stby_lo,
    input logic [7:0] stby_hi,
    input logic [7:0] batt_lo,
    input logic [7:0] batt_hi,
    input logic [1:0] ch_en,
    input logic       grp_en,
    input logic       glb_en,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       irq
);
    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7:2] == 6'd0);

    p_stby_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && ch_en[0] && (stby_rd <= stby_lo || stby_rd > stby_hi))
        |=> reg_rdata[0]);

    p_batt_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && ch_en[1] && (batt_rd <= batt_lo || batt_rd > batt_hi))
        |=> reg_rdata[1]);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[0] && ch_en[0] && !(reg_wr && reg_wdata[0])) |=> reg_rdata[0]);

    p_wr_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_wdata[1] && reg_rdata[1] && ch_en[1]) |=> reg_rdata[1]);

    p_dis_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en[0] |=> !reg_rdata[0]);

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((reg_rdata[1:0] != 2'b00) && grp_en && glb_en));
endmodule

bind vrail_irq_status vrail_irq_status_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .stby_rd   (stby_rd),
    .batt_rd   (batt_rd),
    .stby_lo   (stby_lo),
    .stby_hi   (stby_hi),
    .batt_lo   (batt_lo),
    .batt_hi   (batt_hi),
    .ch_en     (ch_en),
    .grp_en    (grp_en),
    .glb_en    (glb_en),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
);

// File: tb/vrail_irq_status_tb.sv
module vrail_irq_status_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b0;
    logic [7:0] stby_rd = 8'd100, batt_rd = 8'd60;
    logic [7:0] stby_lo = 8'd50, stby_hi = 8'd200;
    logic [7:0] batt_lo = 8'd30, batt_hi = 8'd100;
    logic [1:0] ch_en = 2'b11;
    logic       grp_en = 1'b1, glb_en = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vrail_irq_status dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .stby_rd(stby_rd), .batt_rd(batt_rd),
        .stby_lo(stby_lo), .stby_hi(stby_hi),
        .batt_lo(batt_lo), .batt_hi(batt_hi),
        .ch_en(ch_en), .grp_en(grp_en), .glb_en(glb_en),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // one strobe cycle; result sampled just after the following rising edge
    task automatic sample(input logic [7:0] s, input logic [7:0] b, input logic v = 1'b1);
        @(negedge clk);
        stby_rd = s; batt_rd = b; smp_valid = v;
        @(posedge clk); #1;
        smp_valid = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_wdata = 8'd0;
    endtask

    task automatic wr_and_sample(input logic [7:0] d, input logic [7:0] s, input logic [7:0] b);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = d; stby_rd = s; batt_rd = b; smp_valid = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_wdata = 8'd0; smp_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 status after reset", reg_rdata, 8'h00);
        check("R1 irq after reset", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_stby();
        sample(8'd50, 8'd60);
        check("R2 standby equal low sets", reg_rdata, 8'h01);
        sample(8'd100, 8'd60); wr(8'h01);
        check("R2 cleared for next case", reg_rdata, 8'h00);
        sample(8'd200, 8'd60);
        check("R2 standby equal high no set", reg_rdata, 8'h00);
        sample(8'd201, 8'd60);
        check("R2 standby above high sets", reg_rdata, 8'h01);
        sample(8'd100, 8'd60); wr(8'hFF);
    endtask

    task automatic t_batt();
        sample(8'd100, 8'd30);
        check("R3 battery equal low sets", reg_rdata, 8'h02);
        sample(8'd100, 8'd100);
        check("R3 battery equal high keeps only prior", reg_rdata, 8'h02);
        wr(8'h02);
        check("R3 cleared", reg_rdata, 8'h00);
        sample(8'd100, 8'd101);
        check("R3 battery above high sets", reg_rdata, 8'h02);
        sample(8'd100, 8'd60); wr(8'hFF);
    endtask

    task automatic t_sticky_clear();
        sample(8'd10, 8'd60);
        sample(8'd100, 8'd60);
        check("R4 sticky after return", reg_rdata, 8'h01);
        sample(8'd10, 8'd60);
        wr(8'h01);
        check("R5 clear blocked while violating", reg_rdata, 8'h01);
        wr_and_sample(8'h01, 8'd100, 8'd60);
        check("R5 clear with same-cycle good strobe", reg_rdata, 8'h00);
    endtask

    task automatic t_wr0_prio();
        sample(8'd10, 8'd20);
        sample(8'd100, 8'd60);
        wr(8'h00);
        check("R6 write zero no effect", reg_rdata, 8'h03);
        wr(8'hFE);
        check("R6 bit0 kept when written zero", reg_rdata, 8'h01);
        wr_and_sample(8'h01, 8'd10, 8'd60);
        check("R7 set wins over clear", reg_rdata, 8'h01);
        sample(8'd100, 8'd60); wr(8'hFF);
        check("R5 final clear", reg_rdata, 8'h00);
    endtask

    task automatic t_enable();
        ch_en = 2'b10;
        sample(8'd10, 8'd60);
        check("R8 disabled channel no set", reg_rdata, 8'h00);
        ch_en = 2'b11;
        sample(8'd10, 8'd20);
        check("R8 both set", reg_rdata, 8'h03);
        @(negedge clk); ch_en = 2'b10;
        @(posedge clk); #1;
        check("R8 enable low clears own bit", reg_rdata, 8'h02);
        @(negedge clk); ch_en = 2'b11;
        @(posedge clk); #1;
        check("R8 re-enable no restore", reg_rdata, 8'h02);
        sample(8'd100, 8'd60); wr(8'hFF);
    endtask

    task automatic t_gate();
        sample(8'd10, 8'd60);
        check("R9 irq with gates open", {7'd0, irq}, 8'h01);
        @(negedge clk); grp_en = 1'b0; #1;
        check("R9 group gate off", {7'd0, irq}, 8'h00);
        @(posedge clk); #1;
        check("R9 status kept with group off", reg_rdata, 8'h01);
        @(negedge clk); grp_en = 1'b1; glb_en = 1'b0; #1;
        check("R9 global gate off", {7'd0, irq}, 8'h00);
        @(posedge clk); #1;
        check("R9 status kept with global off", reg_rdata, 8'h01);
        @(negedge clk); glb_en = 1'b1; #1;
        check("R9 irq restored", {7'd0, irq}, 8'h01);
        sample(8'd100, 8'd60); wr(8'hFF);
        check("R9 irq low after clear", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_novalid();
        sample(8'd10, 8'd250, 1'b0);
        check("R10 no strobe no set", reg_rdata, 8'h00);
        check("R1 reserved bits zero", reg_rdata & 8'hFC, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 t_reset();
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_stby();
        t_batt();
        t_sticky_clear();
        t_wr0_prio();
        t_enable();
        t_gate();
        t_novalid();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule